// File: doc/BRIEF.md
# SMT Commit Thread Selector

This block decides which hardware thread gets the next commit slot in a multithreaded out-of-order core. For every thread it receives a commit status, a flag saying whether the oldest reorder-buffer entry is ready, a flag saying whether that thread's buffer is empty, and the sequence number of its oldest entry. A static policy input picks one of three arbitration rules. The result is a valid flag and a thread index.

The selection path is purely combinational, so the commit logic can ask it once for each commit slot within a cycle. The only state is a rotating priority order used by the round-robin rule. That order moves only when the commit logic confirms that it consumed a round-robin grant.

Top module: `smt_commit_select`

## Requirements
- R1: Policy input codes: 0 = aggressive, 1 = round-robin, 2 = oldest-ready, 3 = reserved. The reserved code never yields a selection.
- R2: Each thread has a 3-bit status code, with thread t in bits [3t+2:3t]. The codes are 0 idle, 1 running, 2 squashing, 3 trap-pending and 4 fetch-trap-pending. Head sequence numbers are packed in the same way: thread t sits in bits [SEQ_W*t+SEQ_W-1:SEQ_W*t].
- R3: Under oldest-ready, a thread is a candidate only when all three of these hold: its buffer is non-empty, its status is idle, running or fetch-trap-pending, and its head is ready.
- R4: Among oldest-ready candidates, the one with the smallest head sequence number (unsigned) is selected. On a tie, the lower thread index wins.
- R5: Aggressive selects exactly as oldest-ready does and keeps no state, so repeated queries within a cycle return the same answer.
- R6: Under round-robin, a thread is eligible only when its status is idle or running and its head is ready. The empty flag and the sequence number play no part.
- R7: Under round-robin, the priority order is scanned from front to back, and the first eligible thread is selected.
- R8: When grant_accept_i is high on a clock edge and a round-robin selection is valid, the selected thread moves to the back of the order. The other threads keep their relative order.
- R9: The priority order does not change when grant_accept_i is low, when the policy is not round-robin, or when no thread is selected.
- R10: Reset sets the priority order to ascending thread indices, with thread 0 at the front.
- R11: When no thread qualifies, sel_valid_o is 0 and sel_tid_o is 0.
- R12: With NUM_THREADS = 1, thread 0 is selected whenever its status is idle, running or fetch-trap-pending, whatever the policy or other flags. Otherwise nothing is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | Arbitration policy code |
| thr_status_i | input | 3*NUM_THREADS | Per-thread commit status |
| head_ready_i | input | NUM_THREADS | Head entry ready to retire |
| rob_empty_i | input | NUM_THREADS | Thread's buffer holds no entries |
| head_seq_i | input | SEQ_W*NUM_THREADS | Per-thread head sequence number |
| grant_accept_i | input | 1 | Round-robin grant consumed this cycle |
| sel_valid_o | output | 1 | A thread is selected |
| sel_tid_o | output | TID_W | Selected thread index |

## Verification
The oldest-ready and aggressive paths are driven with distinct sequence numbers, equal sequence numbers, a non-ready head, an empty buffer and every status code. These patterns separate the age comparison, the tie rule and each eligibility term. The same inputs are then applied under round-robin, which must pick by list position and skip fetch-trap-pending threads, so any mix-up of the two eligibility rules shows. Sequences of accepted grants, sparse ready patterns, unconsumed grants, grants under other policies and a mid-run reset exercise the rotation and hold rules. A second instance with one thread covers the single-thread variant.

// File: rtl/smt_commit_pkg.sv
package smt_commit_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RUNNING   = 3'd1,
        ST_SQUASHING = 3'd2,
        ST_TRAP_PEND = 3'd3,
        ST_FTRAP_PEND = 3'd4
    } thr_status_e;

    typedef enum logic [1:0] {
        POL_AGGRESSIVE = 2'd0,
        POL_ROUND_ROBIN = 2'd1,
        POL_OLDEST     = 2'd2,
        POL_RESERVED   = 2'd3
    } commit_policy_e;

    localparam int STATUS_W = 3;
endpackage

// File: rtl/smt_rr_order.sv
module smt_rr_order #(
    parameter int NT    = 4,
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NT-1:0]    elig_i,
    input  logic             advance_i,
    output logic             hit_o,
    output logic [TID_W-1:0] win_tid_o
);
    typedef struct packed {
        logic [NT-1:0][TID_W-1:0] order;
    } rr_state_t;

    rr_state_t        st_d, st_q;
    logic             hit;
    logic [TID_W-1:0] win_tid;
    logic [TID_W-1:0] win_pos;

    always_comb begin
        hit     = 1'b0;
        win_tid = '0;
        win_pos = '0;
        for (int p = 0; p < NT; p++) begin
            if (!hit && elig_i[st_q.order[p]]) begin
                hit     = 1'b1;
                win_tid = st_q.order[p];
                win_pos = TID_W'(p);
            end
        end
        st_d = st_q;
        if (advance_i && hit) begin
            for (int p = 0; p < NT - 1; p++) begin
                if (TID_W'(p) >= win_pos) st_d.order[p] = st_q.order[p+1];
            end
            st_d.order[NT-1] = win_tid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NT; p++) st_q.order[p] <= TID_W'(p);
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o     = hit;
    assign win_tid_o = win_tid;

    logic [NT-1:0][NT-1:0] slot_has;
    always_comb begin
        for (int t = 0; t < NT; t++)
            for (int p = 0; p < NT; p++)
                slot_has[t][p] = (st_q.order[p] == TID_W'(t));
    end

    generate
        for (genvar t = 0; t < NT; t++) begin : g_perm
            // R10
            order_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(slot_has[t]) == 1);
        end
    endgenerate

    // R8
    rotate_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && hit) |=> (st_q.order[NT-1] == $past(win_tid)));

    // R9
    order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(advance_i && hit) |=> $stable(st_q));
endmodule

// File: rtl/smt_oldest_pick.sv
module smt_oldest_pick #(
    parameter int NT    = 4,
    parameter int SEQ_W = 16,
    parameter int TID_W = 2
) (
    input  logic [NT-1:0]       cand_i,
    input  logic [NT*SEQ_W-1:0] seq_i,
    output logic                hit_o,
    output logic [TID_W-1:0]    tid_o
);
    logic [SEQ_W-1:0] best_seq;

    always_comb begin
        hit_o    = 1'b0;
        tid_o    = '0;
        best_seq = '0;
        for (int t = 0; t < NT; t++) begin
            if (cand_i[t] && (!hit_o || seq_i[t*SEQ_W +: SEQ_W] < best_seq)) begin
                hit_o    = 1'b1;
                tid_o    = TID_W'(t);
                best_seq = seq_i[t*SEQ_W +: SEQ_W];
            end
        end
    end
endmodule

// File: rtl/smt_commit_select.sv
module smt_commit_select
    import smt_commit_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 16,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    policy_i,
    input  logic [STATUS_W*NUM_THREADS-1:0] thr_status_i,
    input  logic [NUM_THREADS-1:0]        head_ready_i,
    input  logic [NUM_THREADS-1:0]        rob_empty_i,
    input  logic [SEQ_W*NUM_THREADS-1:0]  head_seq_i,
    input  logic                          grant_accept_i,
    output logic                          sel_valid_o,
    output logic [TID_W-1:0]              sel_tid_o
);
    generate
        if (NUM_THREADS == 1) begin : g_single
            logic [STATUS_W-1:0] st0;
            assign st0 = thr_status_i[STATUS_W-1:0];
            assign sel_valid_o = (st0 == ST_IDLE) || (st0 == ST_RUNNING) ||
                                 (st0 == ST_FTRAP_PEND);
            assign sel_tid_o   = '0;
        end else begin : g_multi
            logic [NUM_THREADS-1:0] cand_old, elig_rr;
            logic                   old_hit, rr_hit, rr_adv;
            logic [TID_W-1:0]       old_tid, rr_tid;

            for (genvar t = 0; t < NUM_THREADS; t++) begin : g_elig
                logic [STATUS_W-1:0] st;
                assign st = thr_status_i[t*STATUS_W +: STATUS_W];
                assign cand_old[t] = !rob_empty_i[t] && head_ready_i[t] &&
                    ((st == ST_IDLE) || (st == ST_RUNNING) || (st == ST_FTRAP_PEND));
                assign elig_rr[t]  = head_ready_i[t] &&
                    ((st == ST_IDLE) || (st == ST_RUNNING));
            end

            smt_oldest_pick #(.NT(NUM_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_oldest (
                .cand_i (cand_old),
                .seq_i  (head_seq_i),
                .hit_o  (old_hit),
                .tid_o  (old_tid)
            );

            assign rr_adv = grant_accept_i && (policy_i == POL_ROUND_ROBIN);

            smt_rr_order #(.NT(NUM_THREADS), .TID_W(TID_W)) u_rr (
                .clk       (clk),
                .rst_n     (rst_n),
                .elig_i    (elig_rr),
                .advance_i (rr_adv),
                .hit_o     (rr_hit),
                .win_tid_o (rr_tid)
            );

            always_comb begin
                sel_valid_o = 1'b0;
                sel_tid_o   = '0;
                unique case (policy_i)
                    POL_AGGRESSIVE, POL_OLDEST: begin
                        sel_valid_o = old_hit;
                        sel_tid_o   = old_hit ? old_tid : '0;
                    end
                    POL_ROUND_ROBIN: begin
                        sel_valid_o = rr_hit;
                        sel_tid_o   = rr_hit ? rr_tid : '0;
                    end
                    default: ;
                endcase
            end

            for (genvar t = 0; t < NUM_THREADS; t++) begin : g_age
                // R4
                oldest_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (sel_valid_o && policy_i != POL_ROUND_ROBIN && cand_old[t]) |->
                    (head_seq_i[sel_tid_o*SEQ_W +: SEQ_W] <= head_seq_i[t*SEQ_W +: SEQ_W]));
            end

            // R6
            rr_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_valid_o && policy_i == POL_ROUND_ROBIN) |->
                (head_ready_i[sel_tid_o] &&
                 thr_status_i[sel_tid_o*STATUS_W +: STATUS_W] <= ST_RUNNING));

            // R3
            old_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_valid_o && policy_i != POL_ROUND_ROBIN) |->
                (!rob_empty_i[sel_tid_o] && head_ready_i[sel_tid_o]));
        end
    endgenerate

    // R1
    reserved_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (NUM_THREADS > 1 && policy_i == POL_RESERVED) |-> !sel_valid_o);

    // R11
    idle_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid_o |-> (sel_tid_o == '0));
endmodule

// File: tb/smt_commit_select_tb.sv
module smt_commit_select_tb;
    localparam int NT = 4;
    localparam int SW = 16;
    localparam int NV = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    pol = 2'd0;
    logic [11:0]   st = '0;
    logic [3:0]    rdy = '0;
    logic [3:0]    emp = '0;
    logic [63:0]   seq = '0;
    logic          acc = 1'b0;
    logic          v;
    logic [1:0]    tid;
    logic [2:0]    st1 = '0;
    logic          v1;
    logic [0:0]    tid1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    smt_commit_select #(.NUM_THREADS(NT), .SEQ_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .policy_i(pol), .thr_status_i(st),
        .head_ready_i(rdy), .rob_empty_i(emp), .head_seq_i(seq),
        .grant_accept_i(acc), .sel_valid_o(v), .sel_tid_o(tid));

    smt_commit_select #(.NUM_THREADS(1), .SEQ_W(SW)) u_dut1 (
        .clk(clk), .rst_n(rst_n), .policy_i(2'd1), .thr_status_i(st1),
        .head_ready_i(1'b0), .rob_empty_i(1'b1), .head_seq_i(16'h0),
        .grant_accept_i(1'b0), .sel_valid_o(v1), .sel_tid_o(tid1));

    // {policy, status, ready, empty, seq t3..t0, exp_valid, exp_tid}
    localparam logic [88:0] VEC [NV] = '{
        {2'd2, 12'h249, 4'hF, 4'h0, 64'h0040_0030_0010_0020, 1'b1, 2'd1},
        {2'd2, 12'h249, 4'hD, 4'h0, 64'h0040_0030_0010_0020, 1'b1, 2'd0},
        {2'd2, 12'h249, 4'hF, 4'h0, 64'h0005_0009_0005_0009, 1'b1, 2'd1},
        {2'd2, 12'h249, 4'hF, 4'h2, 64'h0040_0030_0010_0020, 1'b1, 2'd0},
        {2'd2, 12'h253, 4'hF, 4'h0, 64'h0040_0030_0010_0020, 1'b1, 2'd2},
        {2'd2, 12'h6D4, 4'hF, 4'h0, 64'h0040_0030_0010_0020, 1'b1, 2'd0},
        {2'd2, 12'h000, 4'hF, 4'h0, 64'h0040_0030_0010_0020, 1'b1, 2'd1},
        {2'd2, 12'h492, 4'hF, 4'h0, 64'h0040_0030_0010_0020, 1'b0, 2'd0},
        {2'd0, 12'h249, 4'hF, 4'h0, 64'h0040_0030_0010_0020, 1'b1, 2'd1},
        {2'd0, 12'h6D4, 4'hF, 4'h0, 64'h0040_0030_0010_0020, 1'b1, 2'd0},
        {2'd3, 12'h249, 4'hF, 4'h0, 64'h0040_0030_0010_0020, 1'b0, 2'd0},
        {2'd1, 12'h249, 4'hC, 4'h0, 64'h0040_0030_0010_0020, 1'b1, 2'd2},
        {2'd1, 12'h6D4, 4'hF, 4'h0, 64'h0040_0030_0010_0020, 1'b0, 2'd0},
        {2'd1, 12'h249, 4'hF, 4'hF, 64'h0040_0030_0010_0020, 1'b1, 2'd0}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 2:    return "R4";
            1, 3, 4, 6: return "R3";
            5:       return "R2";
            7:       return "R11";
            8, 9:    return "R5";
            10:      return "R1";
            11:      return "R7";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(string rq, logic av, logic [1:0] at, logic ev, logic [1:0] et);
        n_chk++;
        if (av !== ev || at !== et) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                     rq, av, at, ev, et);
        end
    endtask

    task automatic drive(logic [1:0] p, logic [11:0] s, logic [3:0] r, logic a);
        @(negedge clk);
        pol = p; st = s; rdy = r; emp = 4'h0; acc = a;
        seq = 64'h0040_0030_0010_0020;
        #2;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset order puts thread 0 first
        drive(2'd1, 12'h249, 4'hF, 1'b0);
        chk("R10", v, tid, 1'b1, 2'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {pol, st, rdy, emp, seq} = VEC[i][88:3];
            acc = 1'b0;
            #2;
            chk(tag_of(i), v, tid, VEC[i][2], VEC[i][1:0]);
        end

        // R8: accepted grants rotate the order
        drive(2'd1, 12'h249, 4'hF, 1'b1);
        chk("R8", v, tid, 1'b1, 2'd0);           // order becomes 1,2,3,0
        drive(2'd1, 12'h249, 4'hF, 1'b1);
        chk("R8", v, tid, 1'b1, 2'd1);           // order becomes 2,3,0,1
        drive(2'd1, 12'h249, 4'h3, 1'b1);
        chk("R7", v, tid, 1'b1, 2'd0);           // order becomes 2,3,1,0
        drive(2'd1, 12'h249, 4'hF, 1'b0);
        chk("R8", v, tid, 1'b1, 2'd2);
        drive(2'd1, 12'h249, 4'h3, 1'b0);
        chk("R8", v, tid, 1'b1, 2'd1);

        // R9: grant under another policy leaves the order alone
        drive(2'd2, 12'h249, 4'hF, 1'b1);
        chk("R5", v, tid, 1'b1, 2'd1);
        drive(2'd1, 12'h249, 4'hF, 1'b0);
        chk("R9", v, tid, 1'b1, 2'd2);
        // R9: grant with nothing eligible leaves the order alone
        drive(2'd1, 12'h492, 4'hF, 1'b1);
        chk("R11", v, tid, 1'b0, 2'd0);
        drive(2'd1, 12'h249, 4'hF, 1'b0);
        chk("R9", v, tid, 1'b1, 2'd2);
        // R9: unaccepted grant held over a clock edge
        drive(2'd1, 12'h249, 4'hF, 1'b0);
        chk("R9", v, tid, 1'b1, 2'd2);

        // R10: reset mid-run restores ascending order
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(2'd1, 12'h249, 4'hF, 1'b0);
        chk("R10", v, tid, 1'b1, 2'd0);

        // R12: single-thread variant
        @(negedge clk); st1 = 3'd1; #2;
        chk("R12", v1, {1'b0, tid1}, 1'b1, 2'd0);
        @(negedge clk); st1 = 3'd4; #2;
        chk("R12", v1, {1'b0, tid1}, 1'b1, 2'd0);
        @(negedge clk); st1 = 3'd0; #2;
        chk("R12", v1, {1'b0, tid1}, 1'b1, 2'd0);
        @(negedge clk); st1 = 3'd2; #2;
        chk("R12", v1, {1'b0, tid1}, 1'b0, 2'd0);
        @(negedge clk); st1 = 3'd3; #2;
        chk("R12", v1, {1'b0, tid1}, 1'b0, 2'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule